// File: doc/BRIEF.md
# Paravirtual Device Region Decoder

This block sits behind the two memory-mapped regions of a paravirtual PCI function. It sorts each access to the configuration region by offset. The low part goes to an external common register file. One byte holds the interrupt status. A window of device-specific configuration bytes is stored inside the block. Any other offset gets an error response.

Reading the interrupt status byte returns its value and clears it in the same access. The device interrupt line is therefore dropped by that read. Device-side events set bits in the byte. A write into the device-specific window produces a one-cycle strobe, so the device logic can react to the new setting.

The second region is a doorbell area with one slot per queue, spaced by a fixed power-of-two stride. An aligned write to a slot emits a one-cycle notify pulse carrying the queue number. A misaligned or out-of-range doorbell is flagged and produces no pulse.

Every configuration access gets a response one cycle later. Size codes are: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid.

Top module: `pvbar_decoder`

## Requirements
- R1: A configuration access with a valid size code and an offset below 0x38 drives `com_req` in the same cycle, with `com_off`, `com_we`, `com_size` and `com_wdata` passed through. One cycle later `rsp_valid` is 1 and `rsp_err` is 0. A read returns the `com_rdata` value that was sampled; a write returns 0.
- R2: A read at offset 0x38 returns the interrupt status byte in `rsp_rdata[7:0]`, with the upper bits zero. The byte is cleared at the same edge. A write to offset 0x38 is an error and leaves the byte unchanged.
- R3: `irq` is 1 exactly when the interrupt status byte is nonzero.
- R4: `evt_queue` sets status bit 0 and `evt_config` sets status bit 1. When an event arrives in the same cycle as a clearing read, the read returns the old byte and the new bit stays set.
- R5: A device-specific read at an offset in [0x3C, 0x3C+DEV_BYTES) works on the relative offset r = offset-0x3C.
  - A 1-byte read returns byte r.
  - A 2-byte read returns bytes 2*(r/2) and 2*(r/2)+1.
  - A 4-byte read returns bytes 4*(r/4) through 4*(r/4)+3.
  - The bytes are packed little-endian: lane k sits in bits [8k+7:8k].
- R6: A device-specific write stores the addressed lanes, using the same alignment as R5. One cycle later it pulses `chg_valid` with `chg_off` = r.
- R7: Each of these accesses gets `rsp_err`=1 and `rsp_rdata`=0, and changes no state:
  - offsets 0x39 to 0x3B;
  - offsets at or above 0x3C+DEV_BYTES;
  - any access with size code 3.
- R8: A doorbell write whose offset is a multiple of STRIDE and below NUM_Q*STRIDE gives `ntf_pulse`=1 one cycle later, with `ntf_qid` = offset/STRIDE.
- R9: A doorbell write at an offset that is misaligned or at or above NUM_Q*STRIDE gives `ntf_err`=1 one cycle later, with no pulse and `ntf_qid`=0.
- R10: After reset:
  - `irq`, `rsp_valid`, `rsp_err`, `chg_valid`, `ntf_pulse` and `ntf_err` are 0;
  - every device-specific byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration region access this cycle |
| cfg_we | input | 1 | Access is a write |
| cfg_addr | input | CFG_AW | Byte offset in configuration region |
| cfg_size | input | 2 | Access size code |
| cfg_wdata | input | 32 | Write data, lane 0 in low byte |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access was unsupported |
| rsp_rdata | output | 32 | Read data |
| com_req | output | 1 | Forwarded access to common register file |
| com_we | output | 1 | Forwarded write flag |
| com_off | output | 6 | Forwarded offset |
| com_size | output | 2 | Forwarded size code |
| com_wdata | output | 32 | Forwarded write data |
| com_rdata | input | 32 | Read data from common register file |
| chg_valid | output | 1 | Device-specific configuration was written |
| chg_off | output | $clog2(DEV_BYTES) | Relative offset of that write |
| evt_queue | input | 1 | Queue interrupt event |
| evt_config | input | 1 | Configuration change event |
| irq | output | 1 | Device interrupt request |
| ntf_wr | input | 1 | Doorbell write |
| ntf_off | input | $clog2(NUM_Q*STRIDE)+1 | Doorbell byte offset |
| ntf_pulse | output | 1 | Queue notification |
| ntf_qid | output | $clog2(NUM_Q) | Notified queue index |
| ntf_err | output | 1 | Rejected doorbell |

## Verification
The bench sweeps offsets across every decode boundary: 0x00 and 0x37 on the common side, each byte of 0x38 to 0x3B, and the first, last and one-past-last device bytes. Pass-through, clear-on-read and error handling are each shown to be confined to their own range.

Device-specific bytes are written with mixed sizes at aligned and unaligned offsets, then read back with other sizes. This separates correct lane alignment from plain truncation of the offset. A run of randomized accesses repeats this against the model.

Interrupt events arrive with no read, together with a clearing read, and alongside a rejected write. This tells set-priority apart from clear-priority.

Doorbells are sent to every slot, to misaligned offsets and past the last queue, so that the queue index can be told apart from the raw offset.

// File: rtl/pvbar_pkg.sv
package pvbar_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    localparam logic [31:0] COM_LIMIT = 32'h38;
    localparam logic [31:0] ISR_OFF   = 32'h38;
    localparam logic [31:0] DEV_BASE  = 32'h3C;
endpackage

// File: rtl/pvbar_isr.sv
module pvbar_isr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_queue,
    input  logic       set_config,
    input  logic       rd_clear,
    output logic [7:0] status_o,
    output logic       irq_o
);
    logic [7:0] status_d, status_q;

    always_comb begin
        status_d = rd_clear ? 8'h00 : status_q;
        status_d = status_d | {6'b0, set_config, set_queue};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 8'h00;
        else        status_q <= status_d;
    end

    assign status_o = status_q;
    assign irq_o    = (status_q != 8'h00);
endmodule

// File: rtl/pvbar_devcfg.sv
module pvbar_devcfg #(
    parameter int BYTES = 16,
    parameter int RW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] rel,
    input  logic [1:0]    size,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    import pvbar_pkg::*;

    logic [7:0]    mem_d [BYTES];
    logic [7:0]    mem_q [BYTES];
    logic [RW-1:0] base;
    int            nbytes;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: begin base = rel;                  nbytes = 1; end
            SZ_HALF: begin base = rel & ~RW'(1);        nbytes = 2; end
            default: begin base = rel & ~RW'(3);        nbytes = 4; end
        endcase
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nbytes && (int'(base) + k) < BYTES)
                rdata[8*k +: 8] = mem_q[int'(base) + k];
        end
    end

    always_comb begin
        for (int i = 0; i < BYTES; i++) mem_d[i] = mem_q[i];
        if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (k < nbytes && (int'(base) + k) < BYTES)
                    mem_d[int'(base) + k] = wdata[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < BYTES; i++) begin
            if (!rst_n) mem_q[i] <= 8'h00;
            else        mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/pvbar_notify.sv
module pvbar_notify #(
    parameter int NUM_Q  = 4,
    parameter int STRIDE = 4,
    parameter int OW     = $clog2(NUM_Q*STRIDE) + 1,
    parameter int QW     = $clog2(NUM_Q)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [OW-1:0] off,
    output logic          pulse_o,
    output logic [QW-1:0] qid_o,
    output logic          err_o
);
    localparam int SH    = $clog2(STRIDE);
    localparam int LIMIT = NUM_Q * STRIDE;

    typedef struct packed {
        logic          pulse;
        logic          err;
        logic [QW-1:0] qid;
    } ntf_state_t;

    ntf_state_t st_d, st_q;
    logic       aligned, in_range;

    always_comb begin
        aligned  = ((off & OW'(STRIDE - 1)) == '0);
        in_range = (int'(off) < LIMIT);
        st_d       = '0;
        if (wr) begin
            if (aligned && in_range) begin
                st_d.pulse = 1'b1;
                st_d.qid   = QW'(off >> SH);
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign qid_o   = st_q.qid;
    assign err_o   = st_q.err;
endmodule

// File: rtl/pvbar_decoder.sv
module pvbar_decoder #(
    parameter int CFG_AW    = 8,
    parameter int DEV_BYTES = 16,
    parameter int NUM_Q     = 4,
    parameter int STRIDE    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_req,
    input  logic                            cfg_we,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [1:0]                      cfg_size,
    input  logic [31:0]                     cfg_wdata,
    output logic                            rsp_valid,
    output logic                            rsp_err,
    output logic [31:0]                     rsp_rdata,
    output logic                            com_req,
    output logic                            com_we,
    output logic [5:0]                      com_off,
    output logic [1:0]                      com_size,
    output logic [31:0]                     com_wdata,
    input  logic [31:0]                     com_rdata,
    output logic                            chg_valid,
    output logic [$clog2(DEV_BYTES)-1:0]    chg_off,
    input  logic                            evt_queue,
    input  logic                            evt_config,
    output logic                            irq,
    input  logic                            ntf_wr,
    input  logic [$clog2(NUM_Q*STRIDE):0]   ntf_off,
    output logic                            ntf_pulse,
    output logic [$clog2(NUM_Q)-1:0]        ntf_qid,
    output logic                            ntf_err
);
    import pvbar_pkg::*;

    localparam int          RW      = $clog2(DEV_BYTES);
    localparam int          OW      = $clog2(NUM_Q*STRIDE) + 1;
    localparam int          QW      = $clog2(NUM_Q);
    localparam logic [31:0] DEV_END = DEV_BASE + 32'(DEV_BYTES);

    typedef struct packed {
        logic          rsp_valid;
        logic          rsp_err;
        logic [31:0]   rsp_rdata;
        logic          chg_valid;
        logic [RW-1:0] chg_off;
    } dec_state_t;

    dec_state_t    st_d, st_q;
    logic [31:0]   addr_ext;
    logic          size_ok, hit_com, hit_isr, hit_dev;
    logic          isr_clr, dev_wr;
    logic [RW-1:0] dev_rel;
    logic [7:0]    isr_status;
    logic [31:0]   dev_rdata;

    always_comb begin
        addr_ext = {{(32-CFG_AW){1'b0}}, cfg_addr};
        size_ok  = (acc_size_e'(cfg_size) != SZ_BAD);
        hit_com  = cfg_req && size_ok && (addr_ext < COM_LIMIT);
        hit_isr  = cfg_req && size_ok && (addr_ext == ISR_OFF);
        hit_dev  = cfg_req && size_ok && (addr_ext >= DEV_BASE) && (addr_ext < DEV_END);
        dev_rel  = RW'(addr_ext - DEV_BASE);
        isr_clr  = hit_isr && !cfg_we;
        dev_wr   = hit_dev && cfg_we;

        st_d           = '0;
        st_d.rsp_valid = cfg_req;
        if (cfg_req) begin
            if (hit_com) begin
                st_d.rsp_rdata = cfg_we ? 32'h0 : com_rdata;
            end else if (isr_clr) begin
                st_d.rsp_rdata = {24'h0, isr_status};
            end else if (hit_dev) begin
                if (cfg_we) begin
                    st_d.chg_valid = 1'b1;
                    st_d.chg_off   = dev_rel;
                end else begin
                    st_d.rsp_rdata = dev_rdata;
                end
            end else begin
                st_d.rsp_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_req   = hit_com;
    assign com_we    = cfg_we;
    assign com_off   = cfg_addr[5:0];
    assign com_size  = cfg_size;
    assign com_wdata = cfg_wdata;

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;
    assign chg_valid = st_q.chg_valid;
    assign chg_off   = st_q.chg_off;

    pvbar_isr u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_queue  (evt_queue),
        .set_config (evt_config),
        .rd_clear   (isr_clr),
        .status_o   (isr_status),
        .irq_o      (irq)
    );

    pvbar_devcfg #(.BYTES(DEV_BYTES), .RW(RW)) u_dev (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dev_wr),
        .rel   (dev_rel),
        .size  (cfg_size),
        .wdata (cfg_wdata),
        .rdata (dev_rdata)
    );

    pvbar_notify #(.NUM_Q(NUM_Q), .STRIDE(STRIDE), .OW(OW), .QW(QW)) u_ntf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ntf_wr),
        .off     (ntf_off),
        .pulse_o (ntf_pulse),
        .qid_o   (ntf_qid),
        .err_o   (ntf_err)
    );
endmodule

// File: rtl/pvbar_checker.sv
module pvbar_checker #(
    parameter int CFG_AW    = 8,
    parameter int DEV_BYTES = 16,
    parameter int NUM_Q     = 4,
    parameter int STRIDE    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_req,
    input logic                          cfg_we,
    input logic [CFG_AW-1:0]             cfg_addr,
    input logic [1:0]                    cfg_size,
    input logic                          rsp_valid,
    input logic                          rsp_err,
    input logic [31:0]                   rsp_rdata,
    input logic                          com_req,
    input logic                          chg_valid,
    input logic                          evt_queue,
    input logic                          evt_config,
    input logic                          irq,
    input logic                          ntf_wr,
    input logic                          ntf_pulse,
    input logic                          ntf_err
);
    p_com_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        com_req |-> (cfg_req && cfg_addr < CFG_AW'(8'h38)));

    p_rsp_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> rsp_valid);

    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req |=> !rsp_valid);

    p_isr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we && cfg_size != 2'd3 && cfg_addr == CFG_AW'(8'h38)
         && !evt_queue && !evt_config) |=> !irq);

    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !evt_queue && !evt_config) |=> !irq);

    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_queue || evt_config) |=> irq);

    p_chg_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> $past(cfg_req && cfg_we));

    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0 && rsp_valid));

    p_ntf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_pulse || ntf_err) |-> $past(ntf_wr));

    p_ntf_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ntf_pulse && ntf_err));
endmodule

bind pvbar_decoder pvbar_checker #(
    .CFG_AW(CFG_AW), .DEV_BYTES(DEV_BYTES), .NUM_Q(NUM_Q), .STRIDE(STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_size(cfg_size), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .com_req(com_req),
    .chg_valid(chg_valid), .evt_queue(evt_queue), .evt_config(evt_config),
    .irq(irq), .ntf_wr(ntf_wr), .ntf_pulse(ntf_pulse), .ntf_err(ntf_err)
);

// File: tb/pvbar_decoder_tb.sv
module pvbar_decoder_tb;
    localparam int CFG_AW = 8, DEV_BYTES = 16, NUM_Q = 4, STRIDE = 4;
    localparam int RW = $clog2(DEV_BYTES), OW = $clog2(NUM_Q*STRIDE) + 1, QW = $clog2(NUM_Q);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_req = 0, cfg_we = 0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [1:0] cfg_size = '0;
    logic [31:0] cfg_wdata = '0;
    logic rsp_valid, rsp_err, com_req, com_we, chg_valid, irq, ntf_pulse, ntf_err;
    logic [31:0] rsp_rdata, com_wdata, com_rdata;
    logic [5:0] com_off;
    logic [1:0] com_size;
    logic [RW-1:0] chg_off;
    logic evt_queue = 0, evt_config = 0, ntf_wr = 0;
    logic [OW-1:0] ntf_off = '0;
    logic [QW-1:0] ntf_qid;

    int checks = 0, errors = 0;
    bit run_chk = 0, done = 0;
    string tag = "R10", tag_q = "R10";

    // behavioural model state
    logic [7:0] m_isr;
    logic [7:0] m_dev [DEV_BYTES];
    logic e_rv, e_re, e_cv, e_np, e_ne;
    logic [31:0] e_rd;
    int e_co, e_nq;

    always #5 clk = ~clk;

    assign com_rdata = 32'hC0DE_0000 | {26'h0, com_off};

    pvbar_decoder #(.CFG_AW(CFG_AW), .DEV_BYTES(DEV_BYTES), .NUM_Q(NUM_Q), .STRIDE(STRIDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .com_req(com_req), .com_we(com_we), .com_off(com_off),
        .com_size(com_size), .com_wdata(com_wdata), .com_rdata(com_rdata),
        .chg_valid(chg_valid), .chg_off(chg_off), .evt_queue(evt_queue),
        .evt_config(evt_config), .irq(irq), .ntf_wr(ntf_wr), .ntf_off(ntf_off),
        .ntf_pulse(ntf_pulse), .ntf_qid(ntf_qid), .ntf_err(ntf_err));

    always @(posedge clk) begin
        if (!rst_n) begin
            m_isr = 0;
            for (int i = 0; i < DEV_BYTES; i++) m_dev[i] = 0;
            e_rv = 0; e_re = 0; e_rd = 0; e_cv = 0; e_co = 0; e_np = 0; e_ne = 0; e_nq = 0;
        end else begin
            int a, rel, nb, base;
            bit clr;
            clr = 0;
            e_rv = cfg_req; e_re = 0; e_rd = 0; e_cv = 0; e_co = 0;
            a = int'(cfg_addr);
            if (cfg_req) begin
                if (cfg_size == 2'd3) e_re = 1;
                else if (a < 'h38) begin
                    if (!cfg_we) e_rd = 32'hC0DE_0000 | a;
                end else if (a == 'h38) begin
                    if (cfg_we) e_re = 1;
                    else begin e_rd = {24'h0, m_isr}; clr = 1; end
                end else if (a >= 'h3C && a < 'h3C + DEV_BYTES) begin
                    rel = a - 'h3C;
                    nb = 1 << cfg_size;
                    base = (rel / nb) * nb;
                    if (cfg_we) begin
                        for (int k = 0; k < nb; k++) m_dev[base+k] = cfg_wdata[8*k +: 8];
                        e_cv = 1; e_co = rel;
                    end else begin
                        for (int k = 0; k < nb; k++) e_rd[8*k +: 8] = m_dev[base+k];
                    end
                end else e_re = 1;
            end
            m_isr = (clr ? 8'h00 : m_isr) | {6'h0, evt_config, evt_queue};
            e_np = ntf_wr && (int'(ntf_off) % STRIDE == 0) && (int'(ntf_off) < NUM_Q*STRIDE);
            e_ne = ntf_wr && !e_np;
            e_nq = e_np ? int'(ntf_off) / STRIDE : 0;
        end
        tag_q = tag;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_chk && !done) begin
            chk(tag_q, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
            chk(tag_q, "rsp_err", 32'(rsp_err), 32'(e_re));
            chk(tag_q, "rsp_rdata", rsp_rdata, e_rd);
            chk(tag_q, "chg_valid", 32'(chg_valid), 32'(e_cv));
            if (e_cv) chk(tag_q, "chg_off", 32'(chg_off), 32'(e_co));
            chk(tag_q, "ntf_pulse", 32'(ntf_pulse), 32'(e_np));
            chk(tag_q, "ntf_err", 32'(ntf_err), 32'(e_ne));
            chk(tag_q, "ntf_qid", 32'(ntf_qid), 32'(e_nq));
            chk("R3", "irq", 32'(irq), 32'(m_isr != 0));
            chk("R1", "com_req", 32'(com_req),
                32'(cfg_req && cfg_size != 2'd3 && int'(cfg_addr) < 'h38));
            if (com_req) chk("R1", "com_off", 32'(com_off), 32'(cfg_addr[5:0]));
        end
    end

    task automatic op(string t, bit req, bit we, int addr, int sz, logic [31:0] wd,
                      bit eq = 0, bit ec = 0, bit nw = 0, int noff = 0);
        @(negedge clk); #1;
        tag = t; cfg_req = req; cfg_we = we; cfg_addr = CFG_AW'(addr);
        cfg_size = 2'(sz); cfg_wdata = wd; evt_queue = eq; evt_config = ec;
        ntf_wr = nw; ntf_off = OW'(noff);
        @(negedge clk); #1;
        cfg_req = 0; cfg_we = 0; evt_queue = 0; evt_config = 0; ntf_wr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "irq", 32'(irq), 0);
        chk("R10", "rsp_valid", 32'(rsp_valid), 0);
        chk("R10", "chg_valid", 32'(chg_valid), 0);
        chk("R10", "ntf_pulse", 32'(ntf_pulse | ntf_err), 0);
        #1 rst_n = 1; run_chk = 1;
        op("R10", 1, 0, 'h3C, 2, 0);
        op("R10", 1, 0, 'h48, 2, 0);
        // R1 common range
        op("R1", 1, 0, 'h00, 2, 0);
        op("R1", 1, 0, 'h14, 1, 0);
        op("R1", 1, 0, 'h37, 0, 0);
        op("R1", 1, 1, 'h20, 2, 32'h1234_5678);
        // R4 / R3 / R2 interrupt status
        op("R4", 0, 0, 0, 0, 0, 1, 0);
        op("R2", 1, 0, 'h38, 0, 0);
        op("R4", 0, 0, 0, 0, 0, 1, 1);
        op("R4", 1, 0, 'h38, 0, 0, 1, 0);
        op("R2", 1, 1, 'h38, 0, 32'hFF);
        op("R2", 1, 0, 'h38, 2, 0);
        op("R2", 1, 0, 'h38, 0, 0);
        // R6 / R5 device-specific
        op("R6", 1, 1, 'h3C, 2, 32'h4433_2211);
        op("R6", 1, 1, 'h41, 0, 32'h0000_00AB);
        op("R6", 1, 1, 'h47, 1, 32'h0000_BEEF);
        op("R6", 1, 1, 'h4B, 0, 32'h0000_005A);
        op("R5", 1, 0, 'h3C, 2, 0);
        op("R5", 1, 0, 'h3D, 1, 0);
        op("R5", 1, 0, 'h3F, 2, 0);
        op("R5", 1, 0, 'h42, 0, 0);
        op("R5", 1, 0, 'h46, 1, 0);
        op("R5", 1, 0, 'h48, 2, 0);
        op("R5", 1, 0, 'h40, 2, 0);
        // R7 errors
        op("R7", 1, 0, 'h39, 0, 0);
        op("R7", 1, 1, 'h3B, 0, 32'h77);
        op("R7", 1, 0, 'h4C, 0, 0);
        op("R7", 1, 1, 'h4C, 2, 32'hDEAD_BEEF);
        op("R7", 1, 1, 'h3C, 3, 32'hDEAD_BEEF);
        op("R7", 1, 0, 'h10, 3, 0);
        op("R7", 1, 0, 'h3C, 2, 0);
        // R8 / R9 doorbells
        for (int q = 0; q < NUM_Q; q++) op("R8", 0, 0, 0, 0, 0, 0, 0, 1, q*STRIDE);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 1, 2);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 1, 13);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 1, NUM_Q*STRIDE);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 1, 31);
        // mixed traffic
        for (int i = 0; i < 60; i++) begin
            int sz, ad;
            sz = $urandom_range(0, 2);
            ad = $urandom_range('h36, 'h4D);
            op("R5", 1, 1'($urandom_range(0, 1)), ad, sz, $urandom,
               1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) == 0),
               1'($urandom_range(0, 1)), $urandom_range(0, 20));
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule